// File: doc/BRIEF.md
# Multi-Mode Word RAM with Whole-Array Clear

This block is a single-bank word memory whose data discipline is fixed at elaboration by a parameter. It offers three disciplines. In edge-shared mode one combined port both loads and stores, and stores happen on the clock edge. In level-shared mode the same combined port stores while the load control is low, with no edge needed. In split mode a write-data input and a read-data output stay apart, and a dedicated store control writes on the clock edge. The combined port appears as a data input, a data output and an output-enable, not as a bidirectional bus.

A chip select gates the whole block. A clear input makes every location read as zero at once, and those locations keep reading zero after the clear falls until each is written again. Select, load and store can each be declared unconnected through a parameter. An unconnected control counts as asserted whatever its pin carries. The level-sensitive mode runs on the system clock. It registers address and data every cycle and stores on the first cycle the load control is low, and again on any cycle in which the address or the data differs from the registered copy.

Top module: `mode_ram`

## Requirements
- R1: `rdOe` is 1 exactly when effective select and effective load are both 1. While `rdOe` is 0, `rdData` is all zeros.
- R2: Reads are combinational from the array. A word stored at a clock edge appears on `rdData` from the cycle after that edge, and not before it.
- R3: In edge-shared mode (PORT_MODE = PM_SYNC_SHARED), a rising `clk` edge stores `dataIn` at `addr` when select is 1, load is 0 and `clrIn` is 0.
- R4: In both shared modes, no store happens while load is 1.
- R5: In level-shared mode (PORT_MODE = PM_LEVEL_SHARED), a store happens on the first cycle in which select is 1, load is 0 and clear is 0. A further store happens on each later such cycle in which `addr` or `dataIn` differs from its value in the previous cycle.
- R6: In split mode (PORT_MODE = PM_SPLIT), a rising edge stores `dataIn` at `addr` when select and store are both 1 and clear is 0, whatever the value of load. With store at 0, nothing is stored.
- R7: With effective select at 0, nothing is stored and `rdOe` is 0.
- R8: While `clrIn` is 1, `rdData` is zero for every address and no store happens. After `clrIn` falls, every location reads zero until it is written again.
- R9: When the parameter SEL_FLOAT, LD_FLOAT or STR_FLOAT is 1, the matching pin is ignored and that control counts as asserted.
- R10: After reset, every location reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; stores act on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Store data (combined port or split write input) |
| selIn | input | 1 | Chip select, active high |
| ldIn | input | 1 | Load: 1 drives the read word, 0 enables stores in the shared modes |
| strIn | input | 1 | Store request, used in split mode only |
| clrIn | input | 1 | Whole-array clear, active high |
| rdData | output | DATA_W | Read word, zero when not driven |
| rdOe | output | 1 | Output-enable for the combined port |

## Verification
The assertions assume that the pins are held steady between clock edges. They also assume that no address is read until the reset has been released for at least one clock edge, because their store-then-read properties compare against values sampled at the previous edge. The stimulus changes inputs only one time unit after a rising edge. It releases reset away from an edge, and it shares one set of inputs across four instances that differ only in mode and in which pins are marked unconnected, so one sequence of inputs yields a different expected result for each mode.

// File: rtl/mode_ram_pkg.sv
package mode_ram_pkg;

  typedef enum logic [1:0] {
    PM_SYNC_SHARED  = 2'd0,
    PM_LEVEL_SHARED = 2'd1,
    PM_SPLIT        = 2'd2
  } portModeT;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic wrEn;
    logic wipe;
    logic rdEn;
  } strobeT;

endpackage

// File: rtl/mode_ram_ctrl.sv
module mode_ram_ctrl
  import mode_ram_pkg::*;
#(
  parameter int       ADDR_W    = 6,
  parameter int       DATA_W    = 16,
  parameter portModeT PORT_MODE = PM_SYNC_SHARED
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              selEff,
  input  logic              ldEff,
  input  logic              strEff,
  input  logic              clrIn,
  output strobeT            strobe
);

  logic              armed;
  logic [ADDR_W-1:0] prevAddr;
  logic [DATA_W-1:0] prevData;
  logic              sharedReq;
  logic              splitReq;
  logic              levelReq;

  // registered copies used to detect a change while load stays low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      prevAddr <= '0;
      prevData <= '0;
    end else begin
      armed    <= sharedReq;
      prevAddr <= addr;
      prevData <= dataIn;
    end
  end

  always_comb begin
    sharedReq = selEff && !ldEff && !clrIn;
    splitReq  = selEff && strEff && !clrIn;
    levelReq  = sharedReq && (!armed || (addr != prevAddr) || (dataIn != prevData));
    case (PORT_MODE)
      PM_LEVEL_SHARED: strobe.wrEn = levelReq;
      PM_SPLIT:        strobe.wrEn = splitReq;
      default:         strobe.wrEn = sharedReq;
    endcase
    strobe.wipe = clrIn;
    strobe.rdEn = selEff && ldEff;
  end

endmodule

// File: rtl/mode_ram_dp.sv
module mode_ram_dp
  import mode_ram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  strobeT            strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[addr] <= dataIn;
  end

  // one valid flag per word; clearing them all empties the array at once
  for (genvar g = 0; g < DEPTH; g++) begin : gValid
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   valid[g] <= 1'b0;
      else if (strobe.wipe)                        valid[g] <= 1'b0;
      else if (strobe.wrEn && addr == ADDR_W'(g))  valid[g] <= 1'b1;
    end
  end

  always_comb begin
    if (strobe.rdEn && !strobe.wipe && valid[addr]) rdData = mem[addr];
    else                                            rdData = '0;
  end

endmodule

// File: rtl/mode_ram.sv
module mode_ram
  import mode_ram_pkg::*;
#(
  parameter int       ADDR_W    = 6,
  parameter int       DATA_W    = 16,
  parameter portModeT PORT_MODE = PM_SYNC_SHARED,
  parameter bit       SEL_FLOAT = 1'b0,
  parameter bit       LD_FLOAT  = 1'b0,
  parameter bit       STR_FLOAT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              selIn,
  input  logic              ldIn,
  input  logic              strIn,
  input  logic              clrIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe
);

  logic   selEff;
  logic   ldEff;
  logic   strEff;
  strobeT strobe;

  // an unconnected control reads as asserted
  assign selEff = SEL_FLOAT ? 1'b1 : selIn;
  assign ldEff  = LD_FLOAT  ? 1'b1 : ldIn;
  assign strEff = STR_FLOAT ? 1'b1 : strIn;

  mode_ram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_MODE(PORT_MODE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .selEff(selEff), .ldEff(ldEff), .strEff(strEff), .clrIn(clrIn),
    .strobe(strobe)
  );

  mode_ram_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .strobe(strobe), .rdData(rdData)
  );

  assign rdOe = strobe.rdEn;

endmodule

// File: rtl/mode_ram_chk.sv
module mode_ram_chk
  import mode_ram_pkg::*;
#(
  parameter int       ADDR_W    = 6,
  parameter int       DATA_W    = 16,
  parameter portModeT PORT_MODE = PM_SYNC_SHARED
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataIn,
  input logic              selEff,
  input logic              ldEff,
  input logic              strEff,
  input logic              clrIn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdOe
);

  localparam bit SPLIT = (PORT_MODE == PM_SPLIT);

  logic started;
  logic storeCond;
  logic holdCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  assign storeCond = SPLIT ? (selEff && strEff && !clrIn) : (selEff && !ldEff && !clrIn);
  assign holdCond  = selEff && ldEff && !clrIn && (SPLIT ? !strEff : 1'b1);

  // R1: output enable follows select and load
  p_oe_on_r1: assert property (@(posedge clk) disable iff (!rstN)
    (selEff && ldEff) |-> rdOe);
  // R1, R7
  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(selEff && ldEff) |-> !rdOe);
  // R1: undriven output reads zero
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdOe |-> (rdData == '0));
  // R8: clear forces zero
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrIn |-> (rdData == '0));
  // R8: contents stay zero right after clear falls
  p_clr_sticks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(clrIn) && !clrIn) |-> (rdData == '0));
  // R2, R3, R5, R6: a store is visible on the next cycle
  p_store_seen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(storeCond) && (addr == $past(addr)) && rdOe && !clrIn)
      |-> (rdData == $past(dataIn)));
  // R4, R6: without a store request the read word holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(holdCond) && holdCond && $stable(addr)) |-> $stable(rdData));

endmodule

bind mode_ram mode_ram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_MODE(PORT_MODE)
) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
  .selEff(selEff), .ldEff(ldEff), .strEff(strEff), .clrIn(clrIn),
  .rdData(rdData), .rdOe(rdOe)
);

// File: tb/sim_mode_ram.sv
`timescale 1ns/1ps
module sim_mode_ram;
  import mode_ram_pkg::*;

  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic selIn = 1'b1, ldIn = 1'b1, strIn = 1'b0, clrIn = 1'b0;
  logic [DW-1:0] rd0, rd1, rd2, rd3;
  logic oe0, oe1, oe2, oe3;
  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  mode_ram #(.ADDR_W(AW), .DATA_W(DW), .PORT_MODE(PM_SYNC_SHARED)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .selIn(selIn),
    .ldIn(ldIn), .strIn(strIn), .clrIn(clrIn), .rdData(rd0), .rdOe(oe0));
  mode_ram #(.ADDR_W(AW), .DATA_W(DW), .PORT_MODE(PM_LEVEL_SHARED)) u1 (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .selIn(selIn),
    .ldIn(ldIn), .strIn(strIn), .clrIn(clrIn), .rdData(rd1), .rdOe(oe1));
  mode_ram #(.ADDR_W(AW), .DATA_W(DW), .PORT_MODE(PM_SPLIT)) u2 (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .selIn(selIn),
    .ldIn(ldIn), .strIn(strIn), .clrIn(clrIn), .rdData(rd2), .rdOe(oe2));
  mode_ram #(.ADDR_W(AW), .DATA_W(DW), .PORT_MODE(PM_SPLIT),
             .SEL_FLOAT(1'b1), .STR_FLOAT(1'b1)) u3 (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .selIn(selIn),
    .ldIn(ldIn), .strIn(strIn), .clrIn(clrIn), .rdData(rd3), .rdOe(oe3));

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    selIn = 1'b1; ldIn = 1'b1; strIn = 1'b0; clrIn = 1'b0;
  endtask

  task automatic t_reset();
    idle(); addr = 6'd5; #1;
    chk(rd0, 16'h0, "R10 u0 reads zero after reset");
    chk(rd2, 16'h0, "R10 u2 reads zero after reset");
    chk({15'h0, oe0}, 16'h1, "R1 u0 oe with sel and ld");
  endtask

  task automatic t_shared_store();
    idle(); ldIn = 1'b0; addr = 6'd3; dataIn = 16'hA5A5; #1;
    chk({15'h0, oe0}, 16'h0, "R1 u0 oe low with ld low");
    chk(rd0, 16'h0, "R1 u0 data zero when not driven");
    step();
    ldIn = 1'b1; #1;
    chk(rd0, 16'hA5A5, "R3 u0 edge store");
    chk(rd1, 16'hA5A5, "R5 u1 first low cycle store");
    chk(rd2, 16'h0, "R6 u2 no store with str low");
    chk(rd3, 16'hA5A5, "R9 u3 floating str and sel store");
  endtask

  task automatic t_split_store();
    idle(); strIn = 1'b1; addr = 6'd7; dataIn = 16'h1234;
    step();
    strIn = 1'b0; #1;
    chk(rd2, 16'h1234, "R6 u2 store with ld high");
    chk(rd0, 16'h0, "R4 u0 no store with ld high");
    chk(rd1, 16'h0, "R4 u1 no store with ld high");
  endtask

  task automatic t_level_sweep();
    idle(); ldIn = 1'b0;
    for (int i = 10; i < 14; i++) begin
      addr = AW'(i); dataIn = DW'(16'h0100 + i);
      step();
    end
    addr = 6'd20; dataIn = 16'h0001; step();
    dataIn = 16'h0002; step();
    ldIn = 1'b1;
    for (int i = 10; i < 14; i++) begin
      addr = AW'(i); #1;
      chk(rd1, DW'(16'h0100 + i), "R5 u1 store on address change");
    end
    addr = 6'd20; #1;
    chk(rd1, 16'h0002, "R5 u1 store on data change");
  endtask

  task automatic t_select_off();
    idle(); selIn = 1'b0; ldIn = 1'b0; strIn = 1'b1; addr = 6'd3; dataIn = 16'hFFFF;
    step();
    ldIn = 1'b1; #1;
    chk({15'h0, oe0}, 16'h0, "R7 u0 oe low with sel low");
    chk(rd0, 16'h0, "R7 u0 no drive with sel low");
    chk({15'h0, oe3}, 16'h1, "R9 u3 floating sel drives");
    selIn = 1'b1; strIn = 1'b0; #1;
    chk(rd0, 16'hA5A5, "R7 u0 no store while unselected");
    chk(rd3, 16'hFFFF, "R9 u3 stored despite sel low");
  endtask

  task automatic t_read_timing();
    idle(); strIn = 1'b1; addr = 6'd9; dataIn = 16'h0077; #1;
    chk(rd2, 16'h0, "R2 u2 old value before edge");
    step();
    chk(rd2, 16'h0077, "R2 u2 new value after edge");
    strIn = 1'b0;
  endtask

  task automatic t_clear();
    idle(); clrIn = 1'b1; strIn = 1'b1; addr = 6'd7; dataIn = 16'hBEEF; #1;
    chk(rd2, 16'h0, "R8 u2 zero while clear high");
    chk({15'h0, oe2}, 16'h1, "R8 u2 oe unaffected by clear");
    step();
    ldIn = 1'b0; addr = 6'd30; dataIn = 16'h4242;
    step();
    clrIn = 1'b0; ldIn = 1'b1; strIn = 1'b0; #1;
    chk(rd0, 16'h0, "R8 u0 no store during clear");
    chk(rd2, 16'h0, "R8 u2 no store during clear");
    addr = 6'd7; #1;
    chk(rd2, 16'h0, "R8 u2 stays zero after clear");
    addr = 6'd3; #1;
    chk(rd0, 16'h0, "R8 u0 stays zero after clear");
    addr = 6'd10; #1;
    chk(rd1, 16'h0, "R8 u1 stays zero after clear");
    ldIn = 1'b0; addr = 6'd7; dataIn = 16'h0055; step();
    ldIn = 1'b1; #1;
    chk(rd0, 16'h0055, "R3 u0 store after clear");
  endtask

  initial begin
    #55 rstN = 1'b1;
    step();
    t_reset();
    t_shared_store();
    t_split_store();
    t_level_sweep();
    t_select_off();
    t_read_timing();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule